// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block is the column engine behind a synchronous DRAM controller. It receives read, write and stop commands. Read and write commands carry a bank and a starting column. The block also receives a burst configuration: the length, the wrap order and the read latency. From these it produces one column address per clock, with a beat strobe, until the burst ends, is stopped or is replaced by a newer command.

For a read, a data-valid strobe follows each beat after the programmed latency of two or three clocks. A per-beat mask input gates two outputs: the write enable for write beats, and the output-drive enable for read data. The command channel has no ready signal, because the block accepts a command on every cycle. A command that arrives while a burst is running replaces that burst at once, so the upstream logic never sees back-pressure. The beat outputs carry no ready signal either, because DRAM timing cannot stall.

The burst length, the order and the full-page mode are captured when a read or write command is taken. Read latency is read live, and the controller holds it constant while reads are in flight.

Top module: `sdram_burst_seq`

## Requirements
- R1: A read or write command sampled at a rising edge puts its first beat on the outputs in the following cycle, and one beat follows per cycle after that. The burst length code `cfg_blen` gives the burst size: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. The codes 4, 5 and 6 give a single beat.
- R2: With `cfg_ilv`=0, beat k of a 2, 4 or 8 beat burst addresses (start mod N + k) mod N inside the aligned block of N columns that holds the start column. The upper column bits stay unchanged.
- R3: With `cfg_ilv`=1, beat k addresses the start column with its low log2(N) bits XORed with k.
- R4: In a full-page burst, beat k addresses (start + k) mod 1024. The burst runs without end, wrapping from 1023 to 0, and `cfg_ilv` has no effect on it.
- R5: A stop command (`cmd_op`=2) means no beat is presented in the following cycle or after, until the next read or write.
- R6: `cmd_op` 0 is a read and 1 is a write. Either one, accepted on any cycle, replaces any burst in progress. The next cycle shows beat 0 of the new burst with its bank and direction. `cmd_op` 3 is ignored.
- R7: `rd_valid` is high exactly 2 cycles after a read beat is presented when `cfg_rl3`=0, and 3 cycles after when `cfg_rl3`=1.
- R8: `wr_en` is high in a write beat cycle only if `dm` was low at the edge that launched that beat.
- R9: `rd_oe` equals `rd_valid`, gated low when `dm` was high at the edge that launched the corresponding read beat.
- R10: While reset is held and after it is released, with no command, `beat_valid`, `wr_en`, `rd_valid` and `rd_oe` are low.
- R11: A change to `cfg_blen` or `cfg_ilv` during a burst does not alter that burst's length or address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 read, 1 write, 2 stop, 3 ignored |
| cmd_bank | input | 2 | Bank select of the command |
| cmd_col | input | 10 | Starting column |
| cfg_blen | input | 3 | Burst length code |
| cfg_ilv | input | 1 | 1 selects interleaved order |
| cfg_rl3 | input | 1 | 1 selects read latency 3, else 2 |
| dm | input | 1 | Mask for the beat launched at this edge |
| beat_valid | output | 1 | A beat is presented |
| beat_write | output | 1 | Presented beat belongs to a write |
| beat_bank | output | 2 | Bank of the presented beat |
| beat_col | output | 10 | Column of the presented beat |
| wr_en | output | 1 | Unmasked write beat |
| rd_valid | output | 1 | Read data beat due on the bus |
| rd_oe | output | 1 | Read data should be driven |

## Verification
The overlap that matters here is a new burst's beats and stop commands landing on the same cycles as the latency-delayed data-valid strobe of an earlier read. The first is issued or stopped while the second is still in the pipeline. The bench provokes this in two ways. It interrupts reads with writes two or three cycles after they start. It also issues stops right after read beats, so delayed strobes emerge while the beat outputs already show a write or are idle. A behavioural model keeps its own history of read beats and masks and compares every output on every cycle, so a strobe that gets dropped or misaligned by the overlap is caught in the cycle where it occurs.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_WR   = 2'd1,
    OP_STOP = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  localparam logic [2:0] BL_PAGE = 3'd7;
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [2:0]        cfg_blen,
  input  logic              cfg_ilv,
  input  logic              dm,
  output logic              act_q,
  output logic              wr_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [COL_W-1:0]  start_q,
  output logic [COL_W-1:0]  cnt_q,
  output logic [COL_W-1:0]  mask_q,
  output logic              ilv_q,
  output logic              dm_q
);
  logic [COL_W-1:0] mask_d;
  logic             page_d, page_q, last;
  op_e              op;

  assign op     = op_e'(cmd_op);
  assign page_d = (cfg_blen == BL_PAGE);
  assign last   = !page_q && (cnt_q == mask_q);

  always_comb begin
    case (cfg_blen)
      3'd1:    mask_d = COL_W'(1);
      3'd2:    mask_d = COL_W'(3);
      3'd3:    mask_d = COL_W'(7);
      BL_PAGE: mask_d = '1;
      default: mask_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      bank_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      page_q  <= 1'b0;
      dm_q    <= 1'b0;
    end else begin
      dm_q <= dm;
      if (cmd_valid && (op == OP_RD || op == OP_WR)) begin
        act_q   <= 1'b1;
        wr_q    <= (op == OP_WR);
        bank_q  <= cmd_bank;
        start_q <= cmd_col;
        cnt_q   <= '0;
        mask_q  <= mask_d;
        page_q  <= page_d;
        ilv_q   <= cfg_ilv && !page_d;
      end else if (cmd_valid && op == OP_STOP) begin
        act_q <= 1'b0;
      end else if (act_q) begin
        if (last) act_q <= 1'b0;
        else      cnt_q <= cnt_q + COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/bseq_col_gen.sv
module bseq_col_gen #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] cnt,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] low;

  assign low = ilv ? (start ^ cnt) : (start + cnt);
  assign col = (start & ~mask) | (low & mask);
endmodule

// File: rtl/bseq_rd_pipe.sv
module bseq_rd_pipe #(
  parameter int MAX_RL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_v,
  input  logic in_m,
  input  logic sel_long,
  output logic out_v,
  output logic out_m
);
  localparam int MIN_RL = MAX_RL - 1;

  logic [MAX_RL-1:0] v_q, m_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q[0] <= 1'b0;
      m_q[0] <= 1'b0;
    end else begin
      v_q[0] <= in_v;
      m_q[0] <= in_m;
    end
  end

  for (genvar s = 1; s < MAX_RL; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[s] <= 1'b0;
        m_q[s] <= 1'b0;
      end else begin
        v_q[s] <= v_q[s-1];
        m_q[s] <= m_q[s-1];
      end
    end
  end

  assign out_v = sel_long ? v_q[MAX_RL-1] : v_q[MIN_RL-1];
  assign out_m = sel_long ? m_q[MAX_RL-1] : m_q[MIN_RL-1];
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2,
  parameter int MAX_RL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [2:0]        cfg_blen,
  input  logic              cfg_ilv,
  input  logic              cfg_rl3,
  input  logic              dm,
  output logic              beat_valid,
  output logic              beat_write,
  output logic [BANK_W-1:0] beat_bank,
  output logic [COL_W-1:0]  beat_col,
  output logic              wr_en,
  output logic              rd_valid,
  output logic              rd_oe
);
  logic              act_q, wr_q, ilv_q, dm_q, pipe_m;
  logic [COL_W-1:0]  start_q, cnt_q, mask_q;
  logic [BANK_W-1:0] bank_q;

  bseq_ctrl #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cfg_blen(cfg_blen),
    .cfg_ilv(cfg_ilv), .dm(dm), .act_q(act_q), .wr_q(wr_q),
    .bank_q(bank_q), .start_q(start_q), .cnt_q(cnt_q), .mask_q(mask_q),
    .ilv_q(ilv_q), .dm_q(dm_q)
  );

  bseq_col_gen #(.COL_W(COL_W)) u_col (
    .start(start_q), .cnt(cnt_q), .mask(mask_q), .ilv(ilv_q), .col(beat_col)
  );

  bseq_rd_pipe #(.MAX_RL(MAX_RL)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_v(act_q && !wr_q), .in_m(dm_q),
    .sel_long(cfg_rl3), .out_v(rd_valid), .out_m(pipe_m)
  );

  assign beat_valid = act_q;
  assign beat_write = wr_q;
  assign beat_bank  = bank_q;
  assign wr_en      = act_q && wr_q && !dm_q;
  assign rd_oe      = rd_valid && !pipe_m;
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [COL_W-1:0]  cmd_col,
  input logic              cfg_rl3,
  input logic              beat_valid,
  input logic              beat_write,
  input logic [BANK_W-1:0] beat_bank,
  input logic [COL_W-1:0]  beat_col,
  input logic              wr_en,
  input logic              rd_valid,
  input logic              rd_oe
);
  // R5
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd2 |=> !beat_valid);

  // R6
  new_cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op[1] == 1'b0 |=> beat_valid && beat_col == $past(cmd_col)
      && beat_bank == $past(cmd_bank) && beat_write == $past(cmd_op[0]));

  // R8
  wr_en_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> beat_valid && beat_write);

  // R9
  oe_within_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> rd_valid);

  // R7
  rl_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rl3 |-> rd_valid == $past(beat_valid && !beat_write, 2));

  // R7
  rl_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rl3 |-> rd_valid == $past(beat_valid && !beat_write, 3));
endmodule

bind sdram_burst_seq bseq_chk #(.COL_W(COL_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cfg_rl3(cfg_rl3),
  .beat_valid(beat_valid), .beat_write(beat_write), .beat_bank(beat_bank),
  .beat_col(beat_col), .wr_en(wr_en), .rd_valid(rd_valid), .rd_oe(rd_oe)
);

// File: tb/sdram_burst_seq_test.sv
module sdram_burst_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd3;
  logic [1:0] cmd_bank = '0;
  logic [9:0] cmd_col = '0;
  logic [2:0] cfg_blen = '0;
  logic       cfg_ilv = 1'b0;
  logic       cfg_rl3 = 1'b0;
  logic       dm = 1'b0;
  logic       beat_valid, beat_write, wr_en, rd_valid, rd_oe;
  logic [1:0] beat_bank;
  logic [9:0] beat_col;

  int checks = 0, fails = 0;
  bit finished = 0;

  int m_act = 0, m_wr = 0, m_bank = 0, m_start = 0, m_cnt = 0;
  int m_len = 1, m_ilv = 0, m_dm = 0;
  bit hv [0:3];
  bit hm [0:3];

  always #2 clk = ~clk;

  sdram_burst_seq uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int len_of(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col();
    int base;
    if (m_len == 0) return (m_start + m_cnt) % 1024;
    base = (m_start / m_len) * m_len;
    if (m_ilv != 0) return base + ((m_start % m_len) ^ m_cnt);
    return base + ((m_start % m_len) + m_cnt) % m_len;
  endfunction

  task automatic model_step();
    if (cmd_valid && cmd_op <= 2'd1) begin
      m_act = 1; m_wr = cmd_op; m_bank = cmd_bank; m_start = cmd_col;
      m_cnt = 0; m_len = len_of(cfg_blen);
      m_ilv = (cfg_ilv && m_len != 0) ? 1 : 0;
    end else if (cmd_valid && cmd_op == 2'd2) begin
      m_act = 0;
    end else if (m_act != 0) begin
      if (m_len != 0 && m_cnt == m_len - 1) m_act = 0;
      else m_cnt = (m_cnt + 1) % 1024;
    end
    m_dm = dm;
    for (int i = 3; i > 0; i--) begin
      hv[i] = hv[i-1];
      hm[i] = hm[i-1];
    end
    hv[0] = (m_act != 0 && m_wr == 0);
    hm[0] = m_dm[0];
  endtask

  task automatic compare();
    bit ev;
    bit em;
    string creq;
    chk(beat_valid == (m_act != 0), "R1 beat_valid", beat_valid, m_act);
    if (m_act != 0) begin
      creq = (m_len == 0) ? "R4 col" : (m_ilv != 0 ? "R3 col" : "R2 col");
      chk(beat_col == exp_col(), creq, beat_col, exp_col());
      chk(beat_bank == m_bank && beat_write == m_wr, "R6 bank/dir",
          {beat_bank, beat_write}, m_bank * 2 + m_wr);
    end
    chk(wr_en == (m_act != 0 && m_wr != 0 && m_dm == 0), "R8 wr_en",
        wr_en, (m_act != 0 && m_wr != 0 && m_dm == 0));
    ev = cfg_rl3 ? hv[3] : hv[2];
    em = cfg_rl3 ? hm[3] : hm[2];
    chk(rd_valid == ev, "R7 rd_valid", rd_valid, ev);
    chk(rd_oe == (ev && !em), "R9 rd_oe", rd_oe, ev && !em);
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    cmd_valid = 1'b0;
  endtask

  task automatic issue(input int op, input int bank, input int col);
    cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_bank = bank[1:0]; cmd_col = col[9:0];
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int beats;
    for (int i = 0; i < 4; i++) begin hv[i] = 0; hm[i] = 0; end
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(!beat_valid && !wr_en && !rd_valid && !rd_oe, "R10 reset", beat_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!beat_valid && !rd_valid, "R10 after release", beat_valid, 0);

    for (int rl = 0; rl < 2; rl++)
      for (int il = 0; il < 2; il++)
        for (int bl = 0; bl < 4; bl++) begin
          cfg_rl3 = rl[0]; cfg_ilv = il[0]; cfg_blen = bl[2:0];
          dm = 1'b0;
          issue(0, bl, 13 + bl * 37 + il * 5);
          for (int k = 0; k < 10; k++) begin dm = k[0]; step(); end
          issue(1, 3 - bl, 250 + bl * 11 + il * 3);
          for (int k = 0; k < 10; k++) begin dm = k[1]; step(); end
          dm = 1'b0;
        end

    // R1 reserved length codes give one beat
    cfg_rl3 = 1'b0; cfg_ilv = 1'b0; cfg_blen = 3'd5;
    issue(0, 1, 77);
    step();
    chk(!beat_valid, "R1 reserved code single beat", beat_valid, 0);
    idle(4);

    // R4 full page with interleave requested, crossing 1023 -> 0, long run
    cfg_blen = 3'd7; cfg_ilv = 1'b1;
    issue(0, 2, 1019);
    idle(1030);
    // R5 stop ends the page burst
    issue(2, 0, 0);
    chk(!beat_valid, "R5 stop", beat_valid, 0);
    idle(5);

    // R6 interrupts on consecutive cycles and reads overlapping writes
    cfg_blen = 3'd3; cfg_ilv = 1'b0; cfg_rl3 = 1'b1;
    issue(0, 0, 100);
    idle(2);
    issue(1, 2, 200);
    issue(0, 1, 301);
    issue(0, 3, 402);
    issue(1, 0, 503);
    issue(3, 1, 9);
    idle(3);
    // R5 stop mid read burst while strobes are in flight
    issue(0, 1, 600);
    idle(1);
    issue(2, 0, 0);
    chk(!beat_valid, "R5 stop mid burst", beat_valid, 0);
    idle(5);

    // R11 config change mid burst
    cfg_blen = 3'd2; cfg_ilv = 1'b0; cfg_rl3 = 1'b0;
    issue(1, 2, 42);
    beats = 1;
    cfg_blen = 3'd3; cfg_ilv = 1'b1;
    for (int k = 0; k < 8; k++) begin
      step();
      if (beat_valid) beats++;
    end
    chk(beats == 4, "R11 latched length", beats, 4);

    // R9 masked read beats, both latencies
    cfg_blen = 3'd3; cfg_ilv = 1'b1;
    for (int rl = 0; rl < 2; rl++) begin
      cfg_rl3 = rl[0];
      dm = 1'b1;
      issue(0, 3, 900);
      for (int k = 0; k < 12; k++) begin dm = (k % 3 == 0); step(); end
      dm = 1'b0;
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule